// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one timer channel built around an up-counter, a compare value and a 16-bit control/status word. A start/stop input gates it. While it runs, a selectable prescaler turns the peripheral clock into count ticks. When the count equals the compare value on a tick, the channel latches a match flag and can raise an interrupt or DMA request. In periodic mode it also restarts the count from zero. In free-running mode the count carries on, and a roll past the top value without a match latches an overflow flag.

Software reaches the three registers through a single-cycle register port. Address 0 selects the control word, 1 the counter and 2 the compare value; address 3 reads zero. Register writes do not take effect at once. Control and compare writes land one clock after the write edge. A counter write raises a busy bit and lands two clocks after the write edge. While that bit is set, further counter writes are dropped.

Top module: `cmt_channel`

## Requirements
- R1: After reset the control word reads 0, the counter reads 0 and the compare register reads all ones.
- R2: Control bits 2:0 pick the tick rate: 4 gives one tick per 8 clocks, 5 one per 32, 6 one per 128 and 7 one per clock. Codes 0 to 3 give no ticks. The prescaler restarts whenever the channel enable is low, so N enabled clocks give floor(N/divisor) ticks.
- R3: With control bit 8 set (periodic mode), a tick at which count equals compare loads zero, so one period is compare+1 ticks.
- R4: With control bit 8 clear (free-running mode), a match tick still increments the count, and a tick at the all-ones value wraps the count to zero.
- R5: The overflow flag, control bit 14, is set by a tick that wraps the count from all ones to zero without a match. A wrap that coincides with a match (compare all ones) sets only the match flag.
- R6: The match flag, control bit 15, is set by the tick at which count equals compare.
- R7: A control write with 0 in bit 15 or bit 14 clears that flag; writing 1 leaves it unchanged. Bit 13 ignores writes, and unused bits 12:9 and 6 read 0.
- R8: If a flag clear and a new flag event land in the same clock, the flag ends set.
- R9: A counter write sets control bit 13 (busy) from the write edge until the new value loads, two clocks later. While busy, counter writes are dropped. A load takes priority over a tick in the same clock.
- R10: Control and compare writes take effect one clock after the write edge.
- R11: Control bits 5:4 pick the match request (0 none, 1 DMA, 2 interrupt). The interrupt output is high while the match flag is set with selection 2, or while the overflow flag is set with control bit 7 set. With selection 1, the DMA output pulses for one clock as the match flag is set.
- R12: While the channel enable is low, the count and the flags hold.
- R13: With the debug halt input high and control bit 3 clear, count and prescaler freeze. With bit 3 set, the debug halt is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en_i | input | 1 | Channel run enable from the start/stop register |
| dbg_halt_i | input | 1 | Debug halt request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 counter, 2 compare |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Read data of the selected register |
| irq_req_o | output | 1 | Interrupt request level |
| dma_req_o | output | 1 | One-clock DMA request pulse |

## Verification
A delayed control write that clears the match flag can land in the same clock as a new match. The bench provokes this with the divide-by-1 tick: it places the write edge one clock before the match tick, so the clear and the set land together, and it expects the flag still set and the count back at zero afterwards. It also collides a second counter write with a pending one and expects the first value to load. Separately, it drives the count to the top value in free-running mode, once with the compare value elsewhere (overflow expected) and once with it at all ones (match only expected).

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int CTRL_W     = 16;
    localparam int DIV8_LOG   = 3;
    localparam int DIV32_LOG  = 5;
    localparam int DIV128_LOG = 7;

    localparam int BIT_CMF    = 15;
    localparam int BIT_OVF    = 14;
    localparam int BIT_BUSY   = 13;
    localparam int BIT_PERIOD = 8;
    localparam int BIT_OVFIE  = 7;
    localparam int BIT_DBGRUN = 3;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_DMA  = 2'd1,
        REQ_IRQ  = 2'd2,
        REQ_RSVD = 2'd3
    } req_sel_e;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_COUNT = 2'd1,
        ADDR_CMP   = 2'd2,
        ADDR_NONE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic     periodic;
        logic     ovf_ie;
        req_sel_e req;
        logic     dbg_run;
        logic [2:0] cks;
    } cfg_t;

    function automatic cfg_t unpack_cfg(input logic [CTRL_W-1:0] w);
        cfg_t c;
        c.periodic = w[BIT_PERIOD];
        c.ovf_ie   = w[BIT_OVFIE];
        c.req      = req_sel_e'(w[5:4]);
        c.dbg_run  = w[BIT_DBGRUN];
        c.cks      = w[2:0];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] pack_ctrl(input cfg_t c, input logic cmf,
                                                    input logic ovf, input logic busy);
        return {cmf, ovf, busy, 4'b0000, c.periodic, c.ovf_ie, 1'b0,
                c.req, c.dbg_run, c.cks};
    endfunction

endpackage

// File: rtl/cmt_wr_delay.sv
module cmt_wr_delay #(
    parameter int W        = 32,
    parameter int LAT      = 2,
    parameter bit HOLD_OFF = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    output logic         busy_o,
    output logic         apply_o,
    output logic [W-1:0] data_o
);
    localparam int DW = $clog2(LAT + 1);

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] delay;
        logic [W-1:0]  data;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        apply_o = st_q.valid && (st_q.delay == DW'(1));
        if (apply_o) begin
            st_d.valid = 1'b0;
        end else if (st_q.valid) begin
            st_d.delay = st_q.delay - DW'(1);
        end
        if (wr_i && !(HOLD_OFF && st_q.valid)) begin
            st_d.valid = 1'b1;
            st_d.delay = DW'(LAT - 1);
            st_d.data  = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.valid;
    assign data_o = st_q.data;

    // R9: a write while an earlier one is pending is dropped
    a_r9_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (HOLD_OFF && st_q.valid && !apply_o) |=> (st_q.valid && $stable(st_q.data)));

    // R10: an accepted write is pending on the following cycle
    a_r10_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !st_q.valid) |=> (st_q.valid && st_q.data == $past(data_i)));
endmodule

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
#(
    parameter int PRE_W = DIV128_LOG
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       run_i,
    input  logic [2:0] cks_i,
    output logic       tick_o
);
    localparam logic [PRE_W-1:0] M8   = PRE_W'((1 << DIV8_LOG) - 1);
    localparam logic [PRE_W-1:0] M32  = PRE_W'((1 << DIV32_LOG) - 1);
    localparam logic [PRE_W-1:0] M128 = PRE_W'((1 << DIV128_LOG) - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } st_t;

    st_t st_d, st_q;
    logic [PRE_W-1:0] mask;
    logic             code_ok;

    always_comb begin
        code_ok = 1'b1;
        case (cks_i)
            3'd4:    mask = M8;
            3'd5:    mask = M32;
            3'd6:    mask = M128;
            3'd7:    mask = '0;
            default: begin
                mask    = '0;
                code_ok = 1'b0;
            end
        endcase
        tick_o = run_i && code_ok && ((st_q.pre & mask) == mask);
        st_d   = st_q;
        if (clr_i)      st_d.pre = '0;
        else if (run_i) st_d.pre = st_q.pre + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R13: a frozen prescaler keeps its phase
    a_r13_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clr_i) |=> $stable(st_q.pre));

    // R2: the prescaler restarts from zero after a disable
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.pre == '0));
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             periodic_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             clr_cmf_i,
    input  logic             clr_ovf_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cmf_o,
    output logic             ovf_o,
    output logic             match_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             cmf;
        logic             ovf;
    } st_t;

    st_t  st_d, st_q;
    logic hit, wrap;

    always_comb begin
        hit     = tick_i && (st_q.cnt == cmp_i);
        wrap    = tick_i && !hit && (st_q.cnt == '1);
        match_o = hit && !ld_i;
        st_d    = st_q;
        if (ld_i) begin
            st_d.cnt = ld_val_i;
        end else if (tick_i) begin
            if (hit && periodic_i) st_d.cnt = '0;
            else                   st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (clr_cmf_i) st_d.cmf = 1'b0;
        if (clr_ovf_i) st_d.ovf = 1'b0;
        if (match_o)         st_d.cmf = 1'b1;
        if (wrap && !ld_i)   st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign cmf_o = st_q.cmf;
    assign ovf_o = st_q.ovf;

    // R3: periodic match restarts the count
    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && periodic_i) |=> (st_q.cnt == '0));

    // R8: a set beats a clear landing in the same cycle
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && clr_cmf_i) |=> st_q.cmf);

    // R5: overflow only comes with a wrap to zero
    a_r5_ovf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovf) |-> (st_q.cnt == '0));

    // R12: no tick and no load keeps the count
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !ld_i) |=> $stable(st_q.cnt));

    // R9: a load overrides any tick
    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (st_q.cnt == $past(ld_val_i)));
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int CFG_LAT = 2,
    parameter int CNT_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en_i,
    input  logic             dbg_halt_i,
    input  logic             reg_we_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] reg_rdata_o,
    output logic             irq_req_o,
    output logic             dma_req_o
);
    typedef struct packed {
        cfg_t             cfg;
        logic [CNT_W-1:0] cmp;
        logic             dma;
    } st_t;

    st_t st_d, st_q;

    logic             wr_ctrl, wr_cnt, wr_cmp;
    logic             ctrl_apply, cmp_apply, cnt_apply;
    logic             ctrl_busy, cmp_busy, cnt_busy;
    logic [CTRL_W-1:0] ctrl_wval;
    logic [CNT_W-1:0] cmp_wval, cnt_wval;
    logic             run, tick;
    logic             clr_cmf, clr_ovf;
    logic [CNT_W-1:0] cnt;
    logic             cmf, ovf, match;

    assign wr_ctrl = reg_we_i && (reg_addr_e'(reg_addr_i) == ADDR_CTRL);
    assign wr_cnt  = reg_we_i && (reg_addr_e'(reg_addr_i) == ADDR_COUNT);
    assign wr_cmp  = reg_we_i && (reg_addr_e'(reg_addr_i) == ADDR_CMP);

    cmt_wr_delay #(.W(CTRL_W), .LAT(CFG_LAT), .HOLD_OFF(1'b0)) u_ctrl_wr (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl), .data_i(reg_wdata_i[CTRL_W-1:0]),
        .busy_o(ctrl_busy), .apply_o(ctrl_apply), .data_o(ctrl_wval));

    cmt_wr_delay #(.W(CNT_W), .LAT(CFG_LAT), .HOLD_OFF(1'b0)) u_cmp_wr (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_cmp), .data_i(reg_wdata_i),
        .busy_o(cmp_busy), .apply_o(cmp_apply), .data_o(cmp_wval));

    cmt_wr_delay #(.W(CNT_W), .LAT(CNT_LAT), .HOLD_OFF(1'b1)) u_cnt_wr (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_cnt), .data_i(reg_wdata_i),
        .busy_o(cnt_busy), .apply_o(cnt_apply), .data_o(cnt_wval));

    assign run     = chan_en_i && (!dbg_halt_i || st_q.cfg.dbg_run);
    assign clr_cmf = ctrl_apply && !ctrl_wval[BIT_CMF];
    assign clr_ovf = ctrl_apply && !ctrl_wval[BIT_OVF];

    cmt_prescaler #(.PRE_W(DIV128_LOG)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr_i(!chan_en_i), .run_i(run),
        .cks_i(st_q.cfg.cks), .tick_o(tick));

    cmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .periodic_i(st_q.cfg.periodic),
        .cmp_i(st_q.cmp), .ld_i(cnt_apply), .ld_val_i(cnt_wval),
        .clr_cmf_i(clr_cmf), .clr_ovf_i(clr_ovf),
        .cnt_o(cnt), .cmf_o(cmf), .ovf_o(ovf), .match_o(match));

    always_comb begin
        st_d     = st_q;
        st_d.dma = match && (st_q.cfg.req == REQ_DMA);
        if (ctrl_apply) st_d.cfg = unpack_cfg(ctrl_wval);
        if (cmp_apply)  st_d.cmp = cmp_wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= '0;
            st_q.cmp <= '1;
            st_q.dma <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr_e'(reg_addr_i))
            ADDR_CTRL:  reg_rdata_o = CNT_W'(pack_ctrl(st_q.cfg, cmf, ovf, cnt_busy));
            ADDR_COUNT: reg_rdata_o = cnt;
            ADDR_CMP:   reg_rdata_o = st_q.cmp;
            default:    reg_rdata_o = '0;
        endcase
    end

    assign irq_req_o = (cmf && (st_q.cfg.req == REQ_IRQ)) || (ovf && st_q.cfg.ovf_ie);
    assign dma_req_o = st_q.dma;

    // R11: a DMA pulse only ever accompanies a set match flag
    a_r11_dma_flag: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |-> cmf);

    // R9: an accepted counter write raises busy on the next cycle
    a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && !cnt_busy) |=> cnt_busy);

    // R10: a control write is visible exactly one cycle after its write edge
    a_r10_ctrl_lat: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !ctrl_busy) |=> !$stable(ctrl_busy) || ctrl_busy);
endmodule

// File: tb/cmt_channel_tb.sv
module cmt_channel_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         chan_en = 1'b0;
    logic         dbg_halt = 1'b0;
    logic         we = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         irq, dma;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    cmt_channel #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .chan_en_i(chan_en), .dbg_halt_i(dbg_halt),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_req_o(irq), .dma_req_o(dma));

    typedef struct packed {
        logic [2:0]  cks;
        logic [31:0] cmp;
        logic [15:0] n;
        logic [31:0] exp_cnt;
        logic        exp_cmf;
    } vec_t;

    // R2 / R3 / R6: prescaler rate, periodic restart and match flag
    localparam vec_t VECS [8] = '{
        '{3'd7, 32'd9,   16'd5,   32'd5, 1'b0},
        '{3'd7, 32'd9,   16'd10,  32'd0, 1'b1},
        '{3'd4, 32'd3,   16'd40,  32'd1, 1'b1},
        '{3'd5, 32'd100, 16'd100, 32'd3, 1'b0},
        '{3'd6, 32'd1,   16'd300, 32'd0, 1'b1},
        '{3'd7, 32'd0,   16'd7,   32'd0, 1'b1},
        '{3'd4, 32'd20,  16'd63,  32'd7, 1'b0},
        '{3'd0, 32'd5,   16'd50,  32'd0, 1'b0}
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        chan_en = 1'b1;
        repeat (n) @(negedge clk);
        chan_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(2'd1, v); chk("R1 count", v, 32'h0);
        rd(2'd2, v); chk("R1 compare", v, 32'hFFFF_FFFF);

        // R9: busy window, late load, second write dropped
        @(negedge clk);
        we = 1'b1; addr = 2'd1; wdata = 32'h55;
        @(negedge clk);
        wdata = 32'h77; addr = 2'd1;
        #1 chk("R9 old count after write edge", rdata, 32'h0);
        addr = 2'd0;
        #1 chk("R9 busy bit set", W'(rdata[13]), 32'h1);
        addr = 2'd1;
        @(negedge clk);
        we = 1'b0;
        #1 chk("R9 count not yet loaded", rdata, 32'h0);
        @(negedge clk);
        #1 chk("R9 count loaded, second write dropped", rdata, 32'h55);
        addr = 2'd0;
        #1 chk("R9 busy cleared", W'(rdata[13]), 32'h0);

        // R10: control write latency
        @(negedge clk);
        we = 1'b1; addr = 2'd0; wdata = 32'h0107;
        @(negedge clk);
        we = 1'b0;
        #1 chk("R10 ctrl unchanged at write edge", rdata, 32'h0);
        @(negedge clk);
        #1 chk("R10 ctrl applied", rdata, 32'h0107);

        // table walk
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, W'(16'h0100 | 16'(VECS[i].cks)));
            wr(2'd2, VECS[i].cmp);
            wr(2'd1, 32'h0);
            run(int'(VECS[i].n));
            rd(2'd1, v); chk("R2/R3 vector count", v, VECS[i].exp_cnt);
            rd(2'd0, v); chk("R6 vector match flag", W'(v[15]), W'(VECS[i].exp_cmf));
        end

        // R7: flag write-1 keeps, write-0 clears, busy read-only
        wr(2'd0, 32'h0107);
        wr(2'd2, 32'h0);
        wr(2'd1, 32'h0);
        run(1);
        wr(2'd0, 32'h8107);
        rd(2'd0, v); chk("R7 write 1 keeps flag", W'(v[15]), 32'h1);
        wr(2'd0, 32'h3F07);
        rd(2'd0, v); chk("R7 write 0 clears, busy and unused read 0", v, 32'h0107);

        // R11: interrupt from match flag
        wr(2'd0, 32'h0127);
        @(negedge clk); chk("R11 irq low without flag", W'(irq), 32'h0);
        run(1);
        @(negedge clk); chk("R11 irq with match flag", W'(irq), 32'h1);
        wr(2'd0, 32'h8107);
        @(negedge clk); chk("R11 irq off with no request", W'(irq), 32'h0);

        // R4 / R5: free-run wrap with overflow
        wr(2'd0, 32'h0007);
        wr(2'd2, 32'd5);
        wr(2'd1, 32'hFFFF_FFFD);
        run(3);
        rd(2'd1, v); chk("R4 wrap to zero", v, 32'h0);
        rd(2'd0, v); chk("R5 overflow set, no match", W'(v[15:14]), 32'h1);
        @(negedge clk); chk("R11 irq low, overflow irq disabled", W'(irq), 32'h0);
        wr(2'd0, 32'hC087);
        @(negedge clk); chk("R11 overflow irq", W'(irq), 32'h1);
        run(6);
        rd(2'd1, v); chk("R4 free-run passes compare", v, 32'd6);
        rd(2'd0, v); chk("R6 match in free-run", W'(v[15]), 32'h1);

        // R5: wrap coinciding with match
        wr(2'd0, 32'h0007);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd1, 32'hFFFF_FFFE);
        run(2);
        rd(2'd1, v); chk("R5 count after wrap", v, 32'h0);
        rd(2'd0, v); chk("R5 match only", W'(v[15:14]), 32'h2);

        // R11: DMA pulse
        wr(2'd0, 32'h0117);
        wr(2'd2, 32'd2);
        wr(2'd1, 32'h0);
        @(negedge clk);
        chan_en = 1'b1;
        @(negedge clk); chk("R11 dma idle 1", W'(dma), 32'h0);
        @(negedge clk); chk("R11 dma idle 2", W'(dma), 32'h0);
        @(negedge clk); chk("R11 dma pulse", W'(dma), 32'h1);
        chan_en = 1'b0;
        @(negedge clk); chk("R11 dma single cycle", W'(dma), 32'h0);

        // R12: hold while disabled
        wr(2'd0, 32'h0107);
        wr(2'd2, 32'h1000);
        wr(2'd1, 32'h30);
        repeat (20) @(negedge clk);
        rd(2'd1, v); chk("R12 hold while disabled", v, 32'h30);
        rd(2'd0, v); chk("R12 flags hold", W'(v[15:14]), 32'h0);

        // R13: debug halt
        dbg_halt = 1'b1;
        run(10);
        rd(2'd1, v); chk("R13 frozen under halt", v, 32'h30);
        wr(2'd0, 32'h010F);
        run(10);
        rd(2'd1, v); chk("R13 halt ignored with bit 3", v, 32'h3A);
        dbg_halt = 1'b0;

        // R8: clear and match in the same cycle
        wr(2'd0, 32'h0107);
        wr(2'd2, 32'd4);
        wr(2'd1, 32'h0);
        @(negedge clk);
        chan_en = 1'b1;
        repeat (3) @(negedge clk);
        we = 1'b1; addr = 2'd0; wdata = 32'h0107;
        @(negedge clk);
        we = 1'b0;
        @(negedge clk);
        chan_en = 1'b0;
        addr = 2'd0;
        #1 chk("R8 set wins over clear", W'(rdata[15]), 32'h1);
        addr = 2'd1;
        #1 chk("R3 restart at match", rdata, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule